// File: doc/BRIEF.md
# Two-Wire Register-Access Slave for a Quad Wiper Register File

This block connects a four-channel wiper-control register file to a two-wire I2C bus. Both bus lines pass through synchronisers into the system clock domain. The block then recognises START and STOP conditions, collects bits on rising SCL edges and changes its own SDA drive only while SCL is low. A transaction begins with an identification byte. That byte must carry a fixed device code and the values on three external select pins. A register address byte follows, and for a write a data byte comes after it. Each accepted byte is acknowledged by pulling SDA low for the ninth clock. Any other identification byte is refused, and the block then ignores the bus until the next START.

On the inside, the block presents a plain register port: an address, write data and a one-cycle write strobe, plus a read-data input that the register file drives combinationally from the address. A read uses a repeated START with the read flag set after the address byte. The block then shifts out the addressed register's value, most significant bit first. When a STOP ends a transaction that delivered a data byte, a one-cycle commit pulse tells the non-volatile storage controller to start its write cycle.

Top module: `wiperBusSlave`

## Requirements
- R1: After reset the block releases SDA (`sdaPullLow` = 0) and holds `regWrEn` and `commitPulse` low.
- R2: A falling SDA while SCL is high (START) restarts reception of an identification byte from any state. A rising SDA while SCL is high (STOP) returns the block to idle from any state. A STOP in the middle of a transaction produces no write.
- R3: The identification byte is acknowledged (SDA held low through the ninth clock) if and only if bits 7:4 equal the device code (default 4'b0101) and bits 3:1 equal `devSel`. Bit 0 is the direction: 0 for write, 1 for read.
- R4: After a refused identification byte, the block acknowledges no further byte, issues no write and leaves `regAddr` unchanged until the next START.
- R5: The byte after an accepted write-direction identification byte is acknowledged and appears on `regAddr`.
- R6: The next byte is acknowledged. It produces exactly one single-cycle `regWrEn` pulse, with `regWrData` equal to that byte and `regAddr` equal to the address byte.
- R7: Any byte after the data byte in the same transaction is not acknowledged and causes no further write.
- R8: `commitPulse` is a single-cycle pulse that follows a STOP only when the transaction delivered an accepted data byte. Reads, refused transactions and aborted transactions give none.
- R9: A repeated START carrying the matching identification byte with bit 0 = 1 is acknowledged. The block then drives `regRdData` for the current `regAddr` onto SDA, most significant bit first, one bit per SCL low phase.
- R10: After the eighth read bit the block releases SDA for the master's acknowledge bit. A master ACK (SDA low) repeats the same register value. A master NACK (SDA high) leaves SDA released until the next START.
- R11: With SCL low phases of at least four system clocks, `sdaPullLow` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| devSel | input | 3 | Board-strapped select pins matched against ID bits 3:1 |
| sdaPullLow | output | 1 | 1 drives the data line low; 0 releases it |
| regAddr | output | 8 | Register address latched from the address byte |
| regWrData | output | 8 | Write data, valid with `regWrEn` |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdData | input | 8 | Register file contents at `regAddr` |
| commitPulse | output | 1 | One-cycle pulse that starts the non-volatile write after a STOP |

## Verification
The identification check is swept over all eight select-pin values against all eight address fields in the ID byte, so an acknowledge on any wrong pairing or a missing one on the right pairing shows up at once. A separate sweep over all sixteen device codes separates a correct code compare from a partial one. Writes run over addresses and data computed from a loop index, so a bit-order or latching error changes a visible value. Reads return the address XORed with a constant from the bench's register model, which catches shifting order and off-by-one bit counts. Aborted, refused, over-long and read transactions are each followed by a STOP to show that only completed writes produce a commit pulse.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RX_ID,
    ST_ACK_ID,
    ST_RX_ADDR,
    ST_ACK_ADDR,
    ST_RX_DATA,
    ST_ACK_DATA,
    ST_TX,
    ST_ACK_TX,
    ST_TX_RELOAD,
    ST_IGNORE
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic clrCnt;
    logic latchAddr;
    logic writeByte;
  } dpCtl_t;

endpackage

// File: rtl/wbsSync.sv
module wbsSync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wbsDatapath.sv
module wbsDatapath
  import wbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] regRdData,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              sdaBit,
  output logic [DATA_W-1:0] rxByte,
  output logic              txMsb,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [DATA_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn
);
  logic sclS, sdaS, sclD, sdaD;
  logic [DATA_W-1:0] txShift;

  wbsSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .d(sclIn), .q(sclS));
  wbsSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .d(sdaIn), .q(sdaS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;
  assign sdaBit    = sdaS;
  assign txMsb     = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      bitCnt <= '0;
    end else begin
      if (ctl.shiftIn) rxByte <= {rxByte[DATA_W-2:0], sdaS};
      if (ctl.clrCnt) bitCnt <= '0;
      else if (ctl.shiftIn || ctl.shiftOut) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= {DATA_W{1'b1}};
    else if (ctl.loadTx) txShift <= regRdData;
    else if (ctl.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAddr   <= '0;
      regWrData <= '0;
      regWrEn   <= 1'b0;
    end else begin
      regWrEn <= ctl.writeByte;
      if (ctl.latchAddr) regAddr <= rxByte;
      if (ctl.writeByte) regWrData <= rxByte;
    end
  end
endmodule

// File: rtl/wbsControl.sv
module wbsControl
  import wbs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PIN_W = 3,
  parameter logic [DATA_W-PIN_W-2:0] DEV_CODE = 4'b0101,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int CODE_W = DATA_W - PIN_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              sdaBit,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txMsb,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [PIN_W-1:0]  devSel,
  output dpCtl_t            ctl,
  output logic              sdaPullLow,
  output logic              commitPulse
);
  busState_t state, nextState;
  logic readMode, wrPending, captureRw;
  logic byteDone, lastTxBit, idMatch;

  assign byteDone  = sclFall && (bitCnt == CNT_W'(DATA_W));
  assign lastTxBit = (bitCnt == CNT_W'(DATA_W - 1));
  assign idMatch   = (rxByte[DATA_W-1 -: CODE_W] == DEV_CODE) &&
                     (rxByte[PIN_W:1] == devSel);

  always_comb begin
    nextState = state;
    ctl       = '0;
    captureRw = 1'b0;
    if (stopSeen) begin
      nextState = ST_IDLE;
    end else if (startSeen) begin
      nextState  = ST_RX_ID;
      ctl.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_RX_ID: begin
          if (sclRise) ctl.shiftIn = 1'b1;
          else if (byteDone) begin
            captureRw = idMatch;
            nextState = idMatch ? ST_ACK_ID : ST_IGNORE;
          end
        end
        ST_ACK_ID: begin
          if (sclFall) begin
            ctl.clrCnt = 1'b1;
            if (readMode) begin
              ctl.loadTx = 1'b1;
              nextState  = ST_TX;
            end else begin
              nextState = ST_RX_ADDR;
            end
          end
        end
        ST_RX_ADDR: begin
          if (sclRise) ctl.shiftIn = 1'b1;
          else if (byteDone) begin
            ctl.latchAddr = 1'b1;
            nextState     = ST_ACK_ADDR;
          end
        end
        ST_ACK_ADDR: begin
          if (sclFall) begin
            ctl.clrCnt = 1'b1;
            nextState  = ST_RX_DATA;
          end
        end
        ST_RX_DATA: begin
          if (sclRise) ctl.shiftIn = 1'b1;
          else if (byteDone) begin
            ctl.writeByte = 1'b1;
            nextState     = ST_ACK_DATA;
          end
        end
        ST_ACK_DATA: begin
          if (sclFall) nextState = ST_IGNORE;
        end
        ST_TX: begin
          if (sclFall) begin
            if (lastTxBit) nextState = ST_ACK_TX;
            else ctl.shiftOut = 1'b1;
          end
        end
        ST_ACK_TX: begin
          if (sclRise) nextState = sdaBit ? ST_IGNORE : ST_TX_RELOAD;
        end
        ST_TX_RELOAD: begin
          if (sclFall) begin
            ctl.clrCnt = 1'b1;
            ctl.loadTx = 1'b1;
            nextState  = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      readMode    <= 1'b0;
      wrPending   <= 1'b0;
      commitPulse <= 1'b0;
    end else begin
      state       <= nextState;
      commitPulse <= stopSeen && wrPending;
      if (captureRw) readMode <= rxByte[0];
      if (stopSeen) wrPending <= 1'b0;
      else if (ctl.writeByte) wrPending <= 1'b1;
    end
  end

  always_comb begin
    unique case (state)
      ST_ACK_ID, ST_ACK_ADDR, ST_ACK_DATA: sdaPullLow = 1'b1;
      ST_TX:                               sdaPullLow = ~txMsb;
      default:                             sdaPullLow = 1'b0;
    endcase
  end
endmodule

// File: rtl/wiperBusSlave.sv
module wiperBusSlave
  import wbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W = 8,
  parameter int PIN_W = 3,
  parameter logic [DATA_W-PIN_W-2:0] DEV_CODE = 4'b0101,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [PIN_W-1:0]  devSel,
  output logic              sdaPullLow,
  output logic [DATA_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  input  logic [DATA_W-1:0] regRdData,
  output logic              commitPulse
);
  dpCtl_t ctl;
  logic sclRise, sclFall, startSeen, stopSeen, sdaBit, txMsb;
  logic [DATA_W-1:0] rxByte;
  logic [CNT_W-1:0] bitCnt;

  wbsDatapath #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .regRdData(regRdData), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaBit(sdaBit),
    .rxByte(rxByte), .txMsb(txMsb), .bitCnt(bitCnt), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn));

  wbsControl #(.DATA_W(DATA_W), .PIN_W(PIN_W), .DEV_CODE(DEV_CODE)) u_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaBit(sdaBit),
    .rxByte(rxByte), .txMsb(txMsb), .bitCnt(bitCnt), .devSel(devSel),
    .ctl(ctl), .sdaPullLow(sdaPullLow), .commitPulse(commitPulse));
endmodule

// File: rtl/wbsChecker.sv
module wbsChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaPullLow,
  input logic [DATA_W-1:0] regAddr,
  input logic              regWrEn,
  input logic              commitPulse
);
  // R6: write strobe lasts a single cycle
  assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R5: address does not move while a write is issued
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $stable(regAddr));

  // R8: commit pulse lasts a single cycle
  assert_commit_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |=> !commitPulse);

  // R8: commit comes from a STOP, never alongside a write strobe
  assert_commit_apart_R8: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> !regWrEn);

  // R11: drive engages only while the bus clock is low
  assert_drive_on_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn);

  // R11: drive is released only while the bus clock is low
  assert_drive_off_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> !sclIn);
endmodule

bind wiperBusSlave wbsChecker #(.DATA_W(DATA_W)) u_wbsChecker (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .regAddr(regAddr), .regWrEn(regWrEn), .commitPulse(commitPulse));

// File: tb/tb_wiperBusSlave.sv
module tb_wiperBusSlave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] devSel = 3'd5;
  logic sdaPullLow, regWrEn, commitPulse;
  logic [7:0] regAddr, regWrData, regRdData;
  logic sdaLine;

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  int commitCount = 0;
  logic [7:0] lastAddr = '0;
  logic [7:0] lastData = '0;
  bit finished = 0;

  localparam logic [3:0] CODE = 4'b0101;
  localparam logic [7:0] RD_MASK = 8'h5A;

  always #5 clk = ~clk;

  assign sdaLine   = sdaM & ~sdaPullLow;
  assign regRdData = regAddr ^ RD_MASK;   // bench register model

  wiperBusSlave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .devSel(devSel),
    .sdaPullLow(sdaPullLow), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .commitPulse(commitPulse));

  always @(posedge clk) begin
    if (regWrEn) begin
      wrCount  <= wrCount + 1;
      lastAddr <= regAddr;
      lastData <= regWrData;
    end
    if (commitPulse) commitCount <= commitCount + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(5);
    sclM = 1'b1; tick(10);
    sdaM = 1'b0; tick(10);
    sclM = 1'b0; tick(5);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(5);
    sclM = 1'b1; tick(10);
    sdaM = 1'b1; tick(10);
  endtask

  task automatic bitOut(input logic b);
    sdaM = b; tick(5);
    sclM = 1'b1; tick(10);
    sclM = 1'b0; tick(5);
  endtask

  task automatic bitIn(output logic b);
    sdaM = 1'b1; tick(5);
    sclM = 1'b1; tick(5);
    b = sdaLine; tick(5);
    sclM = 1'b0; tick(5);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) bitOut(v[i]);
    bitIn(a);
    ack = !a;
  endtask

  task automatic recvByte(output logic [7:0] v, input bit masterAck);
    logic b;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      bitIn(b);
      v = {v[6:0], b};
    end
    bitOut(!masterAck);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    summary();
  end

  initial begin
    bit a1, a2, a3, a4;
    logic [7:0] rd;
    int w0, c0;
    logic [7:0] addrHold;

    tick(5);
    rstN = 1'b1;
    tick(5);
    // R1: reset state
    check(sdaPullLow == 1'b0, "R1", "sdaPullLow", sdaPullLow, 0);
    check(regWrEn == 1'b0 && wrCount == 0, "R1", "regWrEn", wrCount, 0);
    check(commitPulse == 1'b0 && commitCount == 0, "R1", "commitPulse", commitCount, 0);

    // R3: select pins against ID address field, all pairings
    for (int pins = 0; pins < 8; pins++) begin
      devSel = pins[2:0];
      for (int f = 0; f < 8; f++) begin
        busStart();
        sendByte({CODE, f[2:0], 1'b0}, a1);
        busStop();
        check(a1 == (f == pins), "R3", $sformatf("ack pins=%0d field=%0d", pins, f),
              a1, (f == pins));
      end
    end
    // R3: all device codes
    devSel = 3'd3;
    for (int c = 0; c < 16; c++) begin
      busStart();
      sendByte({c[3:0], 3'd3, 1'b0}, a1);
      busStop();
      check(a1 == (c == 5), "R3", $sformatf("ack code=%0d", c), a1, (c == 5));
    end
    check(wrCount == 0 && commitCount == 0, "R8", "no commit on ID only", commitCount, 0);

    // R5 R6 R8: write sweep
    devSel = 3'd5;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ad, dt;
      ad = 8'((i * 37 + 3) & 255);
      dt = 8'((i * 73 + 11) & 255);
      w0 = wrCount; c0 = commitCount;
      busStart();
      sendByte({CODE, 3'd5, 1'b0}, a1);
      sendByte(ad, a2);
      check(a1 && a2, "R5", "ID and address acks", {a1, a2}, 3);
      check(regAddr == ad, "R5", "regAddr", regAddr, ad);
      sendByte(dt, a3);
      check(a3, "R6", "data ack", a3, 1);
      check(wrCount == w0 + 1, "R6", "write count", wrCount - w0, 1);
      check(lastAddr == ad && lastData == dt, "R6", "write addr/data",
            {lastAddr, lastData}, {ad, dt});
      check(commitCount == c0, "R8", "no commit before STOP", commitCount - c0, 0);
      busStop();
      tick(10);
      check(commitCount == c0 + 1, "R8", "commit after STOP", commitCount - c0, 1);
    end

    // R7: extra byte after data
    w0 = wrCount;
    busStart();
    sendByte({CODE, 3'd5, 1'b0}, a1);
    sendByte(8'h02, a2);
    sendByte(8'hC3, a3);
    sendByte(8'h3C, a4);
    check(!a4, "R7", "extra byte NACK", a4, 0);
    check(wrCount == w0 + 1 && lastData == 8'hC3, "R7", "single write", wrCount - w0, 1);
    busStop();
    tick(10);

    // R4: refused ID then bytes ignored
    w0 = wrCount; c0 = commitCount; addrHold = regAddr;
    busStart();
    sendByte({CODE, 3'd2, 1'b0}, a1);
    sendByte(8'h77, a2);
    sendByte(8'h99, a3);
    check(!a1 && !a2 && !a3, "R4", "no acks after refusal", {a1, a2, a3}, 0);
    check(wrCount == w0 && regAddr == addrHold, "R4", "no write, addr kept",
          regAddr, addrHold);
    busStop();
    tick(10);
    check(commitCount == c0, "R8", "no commit after refusal", commitCount - c0, 0);

    // R2: STOP mid-transaction aborts without writing
    w0 = wrCount; c0 = commitCount;
    busStart();
    sendByte({CODE, 3'd5, 1'b0}, a1);
    sendByte(8'h11, a2);
    busStop();
    tick(10);
    check(wrCount == w0 && commitCount == c0, "R2", "abort no write/commit",
          wrCount - w0, 0);
    // R2: START restarts even from the ignore state
    busStart();
    sendByte({CODE, 3'd1, 1'b0}, a1);
    busStart();
    sendByte({CODE, 3'd5, 1'b0}, a2);
    busStop();
    check(!a1 && a2, "R2", "restart after refusal", {a1, a2}, 1);

    // R9 R10: reads with master NACK
    for (int i = 0; i < 4; i++) begin
      logic [7:0] ad;
      ad = 8'((i * 85 + 6) & 255);
      w0 = wrCount; c0 = commitCount;
      busStart();
      sendByte({CODE, 3'd5, 1'b0}, a1);
      sendByte(ad, a2);
      busStart();
      sendByte({CODE, 3'd5, 1'b1}, a3);
      check(a3, "R9", "read ID ack", a3, 1);
      recvByte(rd, 1'b0);
      check(rd == (ad ^ RD_MASK), "R9", "read data", rd, ad ^ RD_MASK);
      check(sdaPullLow == 1'b0, "R10", "released after NACK", sdaPullLow, 0);
      busStop();
      tick(10);
      check(wrCount == w0 && commitCount == c0, "R8", "read gives no commit",
            commitCount - c0, 0);
    end

    // R10: master ACK repeats the value
    busStart();
    sendByte({CODE, 3'd5, 1'b0}, a1);
    sendByte(8'hE1, a2);
    busStart();
    sendByte({CODE, 3'd5, 1'b1}, a3);
    recvByte(rd, 1'b1);
    check(rd == (8'hE1 ^ RD_MASK), "R10", "first read byte", rd, 8'hE1 ^ RD_MASK);
    recvByte(rd, 1'b0);
    check(rd == (8'hE1 ^ RD_MASK), "R10", "repeated read byte", rd, 8'hE1 ^ RD_MASK);
    check(sdaPullLow == 1'b0, "R10", "released after final NACK", sdaPullLow, 0);
    busStop();
    tick(20);

    summary();
  end
endmodule